// File: doc/BRIEF.md
# Bit counting unit

This unit returns one of three counts for an XLEN-bit operand: the number of zero bits above the highest one (leading zeros), the number of zero bits below the lowest one (trailing zeros), or the number of one bits (population). When XLEN is 64, each count also has a word mode. In word mode only the low 32 operand bits are examined, and the upper 32 bits play no part in the result.

One leading-zero tree serves both zero counts. A trailing-zero request bit-reverses the operand in front of that tree. In word mode a sentinel one is placed next to the low word, so an all-zero word yields 32 with no separate zero detector. The population count uses a balanced adder tree. The unit is combinational up to a single result register, so the count appears one clock after the request is presented.

Top module: `bcu_count`

## Requirements
- R1: With op = 3'b000 (leading zeros, full width), the count is the number of zeros from bit XLEN-1 downward before the first one. An all-zero operand gives XLEN, and an operand with bit XLEN-1 set gives 0.
- R2: With op = 3'b001 (trailing zeros, full width), the count is the number of zeros from bit 0 upward before the first one. An all-zero operand gives XLEN, and an operand with bit 0 set gives 0.
- R3: When XLEN is 64, op = 3'b100 (leading, word) and op = 3'b101 (trailing, word) scan only bits 31..0. Bit 31 is the top bit for the leading count, and a zero low word gives 32.
- R4: With op = 3'b010 (population, full width), the count is the number of one bits in the whole operand.
- R5: When XLEN is 64, op = 3'b110 (population, word) counts only the one bits in bits 31..0.
- R6: In every word mode, operand bits 63..32 do not change the result.
- R7: The result is zero-extended. Every bit of count above bit log2(XLEN) is 0.
- R8: An op whose low two bits are 2'b11 is reserved and gives a count of 0, with or without op[2].
- R9: count is registered. It shows the result for the op and operand sampled at the previous rising clock edge, stays unchanged between edges, and is 0 while rst_n is low.
- R10: When XLEN is 32, op[2] has no effect, and every count is taken over the full 32 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the result register |
| rst_n | input | 1 | Active-low reset; clears the result |
| op | input | 3 | Select: [1:0] 00 leading, 01 trailing, 10 population, 11 reserved; [2] word mode |
| operand | input | XLEN | Value to be counted |
| count | output | XLEN | Registered count, zero-extended |

## Verification
Every single-bit operand and the all-zero operand are applied in every mode at both widths. A tree that drops or misorders a level reports the wrong position for some bit. A design without a zero sentinel returns a wrong value such as 0 or 63 for a zero input, where XLEN or 32 is expected. Word-mode requests are repeated with random upper halves, so a mask that leaks bits 63..32 shows up as a count above 32 or a population that changes with the upper half. Random operands are compared against a loop-based count, and reserved selects are checked for a zero result.

// File: rtl/bcu_pkg.sv
package bcu_pkg;

    typedef enum logic [1:0] {
        KIND_LEAD  = 2'b00,
        KIND_TRAIL = 2'b01,
        KIND_POP   = 2'b10,
        KIND_RSVD  = 2'b11
    } count_kind_e;

    localparam int WORD_W = 32;

endpackage

// File: rtl/bcu_lzc_tree.sv
module bcu_lzc_tree #(
    parameter int W = 64
) (
    input  logic [W-1:0]         vec,
    output logic [$clog2(W)-1:0] lead,
    output logic                 any
);
    localparam int LOG = $clog2(W);

    // Heap-ordered tree: node i has children 2i (lower half) and 2i+1 (upper half).
    logic [LOG-1:0] ncnt [1:2*W-1];
    logic           nvld [1:2*W-1];

    genvar k;
    generate
        for (k = 0; k < W; k++) begin : g_leaf
            assign nvld[W+k] = vec[k];
            assign ncnt[W+k] = '0;
        end
        for (k = 1; k < W; k++) begin : g_node
            localparam int DEPTH = $clog2(k + 1) - 1;
            localparam int SPAN  = W >> (DEPTH + 1);
            assign nvld[k] = nvld[2*k] | nvld[2*k+1];
            assign ncnt[k] = nvld[2*k+1] ? ncnt[2*k+1]
                                         : ncnt[2*k] + LOG'(SPAN);
        end
    endgenerate

    assign lead = ncnt[1];
    assign any  = nvld[1];

endmodule

// File: rtl/bcu_pop_tree.sv
module bcu_pop_tree #(
    parameter int W = 64
) (
    input  logic [W-1:0]         vec,
    output logic [$clog2(W):0]   ones
);
    localparam int CW = $clog2(W) + 1;

    logic [CW-1:0] nsum [1:2*W-1];

    genvar k;
    generate
        for (k = 0; k < W; k++) begin : g_leaf
            assign nsum[W+k] = CW'(vec[k]);
        end
        for (k = 1; k < W; k++) begin : g_node
            assign nsum[k] = nsum[2*k] + nsum[2*k+1];
        end
    endgenerate

    assign ones = nsum[1];

endmodule

// File: rtl/bcu_count.sv
module bcu_count
    import bcu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      op,
    input  logic [XLEN-1:0] operand,
    output logic [XLEN-1:0] count
);
    localparam int  LOG      = $clog2(XLEN);
    localparam int  CW       = LOG + 1;
    localparam bit  HAS_WORD = (XLEN > WORD_W);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } state_t;

    state_t state_d, state_q;

    count_kind_e     kind;
    logic            word;
    logic [XLEN-1:0] lead_word, trail_word, pop_word;
    logic [XLEN-1:0] lead_src, trail_src, trail_rev;
    logic [XLEN-1:0] scan_vec, pop_vec;
    logic [LOG-1:0]  lz_cnt;
    logic            lz_any;
    logic [CW-1:0]   zero_cnt;
    logic [CW-1:0]   pop_cnt;

    // Word-mode operand shaping: a sentinel one beside the low word caps the scan at 32.
    generate
        if (HAS_WORD) begin : g_word
            assign lead_word  = {operand[WORD_W-1:0], 1'b1, {(XLEN-WORD_W-1){1'b0}}};
            assign trail_word = {{(XLEN-WORD_W-1){1'b0}}, 1'b1, operand[WORD_W-1:0]};
            assign pop_word   = {{(XLEN-WORD_W){1'b0}}, operand[WORD_W-1:0]};
        end else begin : g_full_only
            assign lead_word  = operand;
            assign trail_word = operand;
            assign pop_word   = operand;
        end
    endgenerate

    always_comb begin
        kind      = count_kind_e'(op[1:0]);
        word      = HAS_WORD && op[2];
        lead_src  = word ? lead_word  : operand;
        trail_src = word ? trail_word : operand;
        pop_vec   = word ? pop_word   : operand;
        for (int i = 0; i < XLEN; i++) begin
            trail_rev[i] = trail_src[XLEN-1-i];
        end
        scan_vec  = (kind == KIND_TRAIL) ? trail_rev : lead_src;
    end

    bcu_lzc_tree #(.W(XLEN)) u_lzc (
        .vec  (scan_vec),
        .lead (lz_cnt),
        .any  (lz_any)
    );

    bcu_pop_tree #(.W(XLEN)) u_pop (
        .vec  (pop_vec),
        .ones (pop_cnt)
    );

    always_comb begin
        zero_cnt = lz_any ? {1'b0, lz_cnt} : {1'b1, {LOG{1'b0}}};
        state_d  = state_q;
        unique case (kind)
            KIND_LEAD, KIND_TRAIL: state_d.cnt = zero_cnt;
            KIND_POP:              state_d.cnt = pop_cnt;
            default:               state_d.cnt = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign count = {{(XLEN-CW){1'b0}}, state_q.cnt};

endmodule

// File: rtl/bcu_count_chk.sv
module bcu_count_chk #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic [2:0]      op,
    input logic [XLEN-1:0] operand,
    input logic [XLEN-1:0] count
);
    localparam int LOG = $clog2(XLEN);
    localparam bit HAS_WORD = (XLEN > 32);

    p_zero_ext_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (count >> (LOG + 1)) == '0);

    p_lead_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((op[1:0] == 2'b00) && (!HAS_WORD || !op[2]) && (operand == '0))
        |=> (count == XLEN[XLEN-1:0]));

    p_lead_top_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((op[1:0] == 2'b00) && (!HAS_WORD || !op[2]) && operand[XLEN-1])
        |=> (count == '0));

    p_trail_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((op[1:0] == 2'b01) && operand[0]) |=> (count == '0));

    p_pop_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((op[1:0] == 2'b10) && (!HAS_WORD || !op[2]))
        |=> (count == XLEN'($countones($past(operand)))));

    p_reserved_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op[1:0] == 2'b11) |=> (count == '0));

    generate
        if (HAS_WORD) begin : g_word_chk
            p_word_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (op[2] && (op[1] == 1'b0) && (operand[31:0] == 32'h0))
                |=> (count == XLEN'(32)));

            p_word_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (op == 3'b110)
                |=> (count == XLEN'($countones($past(operand[31:0])))));
        end
    endgenerate

endmodule

bind bcu_count bcu_count_chk #(.XLEN(XLEN)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op      (op),
    .operand (operand),
    .count   (count)
);

// File: tb/bcu_count_bench.sv
module bcu_count_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op = 3'b000;
    logic [63:0] x = 64'h0;
    logic [63:0] cnt64;
    logic [31:0] cnt32;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bcu_count #(.XLEN(64)) u_bcu_count (
        .clk(clk), .rst_n(rst_n), .op(op), .operand(x), .count(cnt64)
    );

    bcu_count #(.XLEN(32)) u_bcu_count_n32 (
        .clk(clk), .rst_n(rst_n), .op(op), .operand(x[31:0]), .count(cnt32)
    );

    function automatic int ref_count(int w, logic [2:0] o, logic [63:0] v);
        int n;
        int r;
        n = (w == 64 && o[2]) ? 32 : w;
        r = 0;
        case (o[1:0])
            2'b00: begin
                r = n;
                for (int i = n - 1; i >= 0; i--) begin
                    if (v[i]) begin r = n - 1 - i; break; end
                end
            end
            2'b01: begin
                r = n;
                for (int i = 0; i < n; i++) begin
                    if (v[i]) begin r = i; break; end
                end
            end
            2'b10: begin
                for (int i = 0; i < n; i++) r += int'(v[i]);
            end
            default: r = 0;
        endcase
        return r;
    endfunction

    function automatic string tag64(logic [2:0] o, logic [63:0] v);
        if (o[1:0] == 2'b11) return "R8";
        if (o[2] && v[63:32] != 32'h0) return "R6";
        case (o)
            3'b000: return "R1";
            3'b001: return "R2";
            3'b010: return "R4";
            3'b110: return "R5";
            default: return "R3";
        endcase
    endfunction

    task automatic check(string req, int dut, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s dut%0d op=%b x=%h got=%0d exp=%0d", req, dut, op, x, got, exp);
        end
    endtask

    // One request per clock: drive at negedge, compare shortly after the next rising edge.
    task automatic apply(logic [2:0] o, logic [63:0] v);
        @(negedge clk);
        op = o;
        x  = v;
        @(posedge clk);
        #1;
        check(tag64(o, v), 64, cnt64, 64'(ref_count(64, o, v)));
        check(o[2] ? "R10" : tag64(o, v), 32, {32'h0, cnt32}, 64'(ref_count(32, o, v)));
        check("R7", 64, {57'h0, cnt64[63:7]}, 64'h0);
    endtask

    initial begin
        logic [63:0] r;
        logic [31:0] held;
        // R9: reset state
        #(CLK_PERIOD * 2 + 1);
        check("R9", 64, cnt64, 64'h0);
        check("R9", 32, {32'h0, cnt32}, 64'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // Exhaustive single-bit and all-zero operands in every select value
        for (int o = 0; o < 8; o++) begin
            apply(3'(o), 64'h0);
            for (int b = 0; b < 64; b++) begin
                apply(3'(o), 64'h1 << b);
            end
        end

        // R6: word modes with junk in the upper half
        for (int b = 0; b < 32; b++) begin
            apply(3'b100, {32'hA5A5_F00F, 32'h1 << b});
            apply(3'b101, {32'hFFFF_FFFF, 32'h1 << b});
            apply(3'b110, {32'h1234_5678, 32'h1 << b});
        end
        apply(3'b100, {32'hFFFF_FFFF, 32'h0});
        apply(3'b101, {32'h8000_0001, 32'h0});
        apply(3'b110, {32'hFFFF_FFFF, 32'h0});

        // Fixed patterns
        apply(3'b010, 64'hFFFF_FFFF_FFFF_FFFF);
        apply(3'b110, 64'hFFFF_FFFF_FFFF_FFFF);
        apply(3'b000, 64'h0000_0000_8000_0000);
        apply(3'b100, 64'h0000_0000_8000_0000);
        apply(3'b001, 64'h8000_0000_0000_0000);
        apply(3'b101, 64'h8000_0000_0000_0000);

        // Random operands in every select value
        for (int n = 0; n < 400; n++) begin
            r = {$urandom(), $urandom()};
            if (n % 4 == 1) r = r & {$urandom(), $urandom()} & {$urandom(), $urandom()};
            if (n % 4 == 2) r = r >> ($urandom() % 64);
            for (int o = 0; o < 8; o++) apply(3'(o), r);
        end

        // R9: count holds between edges after inputs change
        apply(3'b010, 64'h0000_0000_0000_00FF);
        @(negedge clk);
        held = cnt32;
        op = 3'b000;
        x  = 64'h0000_0000_0000_0001;
        #1;
        check("R9", 64, cnt64, 64'd8);
        check("R9", 32, {32'h0, cnt32}, {32'h0, held});
        @(posedge clk);
        #1;
        check("R9", 64, cnt64, 64'd63);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R9 watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule